// File: doc/BRIEF.md
# Keyed-sequence watchdog timer

This block is a watchdog built around a free-running binary counter that advances once per cycle of the `tick` enable. Software keeps the system alive by writing a restart key to the command register before the selected timeout runs out. When the counter runs out, the block emits a one-cycle request pulse. A control bit steers that pulse either to the reset request output or to the non-maskable interrupt request output. The interrupt request is not gated by any interrupt-enable flag.

The watchdog can be stopped only by a three-step sequence. First the restart key is written. Next the control register is written with its run bit at 0. Finally the stop key is written to the command register. A control write that sets the run bit restarts the watchdog at once, and it counts from zero. Both registers share one write port. `wr_sel` chooses the target: 0 selects the control register and 1 selects the command register.

Control register layout:
- bit 0: run
- bits 2:1: timeout select
- bit 3: output select (1 = reset, 0 = interrupt)
- bits 7:4: ignored

Top module: `keyed_wdt`

## Requirements
- R1: After reset the watchdog is running in reset-output mode with timeout select 00, and both request outputs are low.
- R2: With the parameter LONG_LOG2 = L, the timeout in ticks is 2^L for select 00, 2^(L-2) for 01, 2^(L-4) for 10 and 2^(L-6) for 11. The request pulse appears in the cycle that follows the edge taking the tick that completes the timeout.
- R3: The counter advances only in cycles where `tick` is high. Cycles with `tick` low never produce a request.
- R4: Writing 0x4E to the command register clears the counter to zero.
- R5: A command write of any value other than 0x4E has no effect and does not restart the counter. This includes 0xB1 when the unlock sequence is not armed.
- R6: The watchdog stops when three writes occur in this order: command 0x4E, then a control write with bit 0 = 0, then command 0xB1. Command writes of other values may come between the last two steps. Once stopped, no request is raised.
- R7: If the sequence is broken, the watchdog keeps running. This covers a control write with bit 0 = 0 that was not preceded by 0x4E (or followed a control write with bit 0 = 1), and a missing 0xB1.
- R8: While stopped, the counter is held at zero. A control write with bit 0 = 1 restarts the watchdog, which then needs a full timeout from zero.
- R9: On timeout, a one-cycle pulse appears on `wdt_rst_req` when control bit 3 is 1, or on `wdt_nmi_req` when it is 0. The two outputs are never high together.
- R10: After a timeout the counter restarts from zero, so the next request needs another full timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = command register |
| wr_data | input | 8 | Write data |
| wdt_rst_req | output | 1 | Reset request pulse |
| wdt_nmi_req | output | 1 | Non-maskable interrupt request pulse |

## Verification
The bench builds the block with LONG_LOG2 = 8, which gives timeouts of 256, 64, 16 and 4 ticks. Every timeout select can therefore be driven to one tick short of expiry and then to expiry within a few hundred cycles. The 4-tick setting makes the key, unlock and restart scenarios short enough to test each one exactly at its boundary.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int          LONG_LOG2 = 25,
  parameter logic [7:0]  KEY_CLR   = 8'h4E,
  parameter logic [7:0]  KEY_OFF   = 8'hB1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic       wdt_rst_req,
  output logic       wdt_nmi_req
);

  typedef enum logic [1:0] {SQ_IDLE, SQ_KEYED, SQ_ARMED} seq_t;

  seq_t                 seq;
  logic                 active;
  logic                 out_rst;
  logic [1:0]           tsel;
  logic [LONG_LOG2-1:0] cnt;
  logic [LONG_LOG2-1:0] term;

  wire ctrl_wr = wr_en & ~wr_sel;
  wire cmd_wr  = wr_en &  wr_sel;
  wire clr_hit = cmd_wr && (wr_data == KEY_CLR);
  wire off_hit = cmd_wr && (wr_data == KEY_OFF) && (seq == SQ_ARMED);

  assign term = {LONG_LOG2{1'b1}} >> (2 * tsel);
  wire ovf = active && tick && !clr_hit && (cnt >= term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq         <= SQ_IDLE;
      active      <= 1'b1;
      out_rst     <= 1'b1;
      tsel        <= 2'b00;
      cnt         <= '0;
      wdt_rst_req <= 1'b0;
      wdt_nmi_req <= 1'b0;
    end else begin
      wdt_rst_req <= ovf & out_rst;
      wdt_nmi_req <= ovf & ~out_rst;

      if (clr_hit)      seq <= SQ_KEYED;
      else if (off_hit) seq <= SQ_IDLE;
      else if (ctrl_wr) seq <= (seq == SQ_KEYED && !wr_data[0]) ? SQ_ARMED : SQ_IDLE;

      if (ctrl_wr) begin
        tsel    <= wr_data[2:1];
        out_rst <= wr_data[3];
        if (wr_data[0]) active <= 1'b1;
      end
      if (off_hit) active <= 1'b0;

      if (!active || off_hit || clr_hit || ovf) cnt <= '0;
      else if (tick)                            cnt <= cnt + 1'b1;
    end
  end

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wdt_rst_req && wdt_nmi_req));

  p_rst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> !wdt_rst_req);

  p_nmi_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_nmi_req |=> !wdt_nmi_req);

  p_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !(wdt_rst_req || wdt_nmi_req));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (cnt == '0) && !(wdt_rst_req || wdt_nmi_req));

  p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    off_hit |=> !active);

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !(wdt_rst_req || wdt_nmi_req));

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt == '0));

endmodule

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
  localparam int L = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wdt_rst_req, wdt_nmi_req;

  int total = 0;
  int bad = 0;
  int seen = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  keyed_wdt #(.LONG_LOG2(L)) i_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .wdt_rst_req(wdt_rst_req), .wdt_nmi_req(wdt_nmi_req)
  );

  // vector: [13:12] tsel, [11] rst mode, [10:1] tick count, [0] pulse expected
  localparam bit [13:0] VEC [0:7] = '{
    {2'd1, 1'b1, 10'd63, 1'b0}, {2'd1, 1'b1, 10'd64, 1'b1},
    {2'd2, 1'b0, 10'd15, 1'b0}, {2'd2, 1'b0, 10'd16, 1'b1},
    {2'd3, 1'b0, 10'd3,  1'b0}, {2'd3, 1'b0, 10'd4,  1'b1},
    {2'd3, 1'b1, 10'd4,  1'b1}, {2'd2, 1'b1, 10'd16, 1'b1}
  };

  function automatic logic [7:0] ctl(input logic en, input logic [1:0] ts, input logic m);
    return {4'b0, m, ts, en};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      step();
      seen += int'(wdt_rst_req) + int'(wdt_nmi_req);
    end
    tick = 1'b0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 rst low after reset", int'(wdt_rst_req), 0);
    chk("R1 nmi low after reset", int'(wdt_nmi_req), 0);
    ticks(255);
    chk("R1 R2 no request before 2^L", seen, 0);
    ticks(1);
    chk("R1 reset-mode pulse at 2^L", int'(wdt_rst_req), 1);
    chk("R1 nmi quiet in reset mode", int'(wdt_nmi_req), 0);
    step();
    chk("R9 pulse is one cycle", int'(wdt_rst_req), 0);

    for (int v = 0; v < 8; v++) begin
      logic [1:0] ts;
      logic m, e;
      int n;
      ts = VEC[v][13:12]; m = VEC[v][11]; n = int'(VEC[v][10:1]); e = VEC[v][0];
      wr(1'b0, ctl(1'b1, ts, m));
      wr(1'b1, 8'h4E);
      ticks(n);
      chk($sformatf("R2 R9 vec%0d rst", v), int'(wdt_rst_req), int'(e & m));
      chk($sformatf("R2 R9 vec%0d nmi", v), int'(wdt_nmi_req), int'(e & ~m));
      chk($sformatf("R2 vec%0d early pulses", v), seen, int'(e));
      step();
    end

    wr(1'b0, ctl(1'b1, 2'd3, 1'b1));
    wr(1'b1, 8'h4E);
    ticks(3);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      seen += int'(wdt_rst_req) + int'(wdt_nmi_req);
    end
    chk("R3 no count without tick", seen, 0);
    ticks(1);
    chk("R3 fourth tick expires", int'(wdt_rst_req), 1);

    ticks(3);
    chk("R10 restart from zero, 3 ticks quiet", seen, 0);
    ticks(1);
    chk("R10 next expiry after full timeout", int'(wdt_rst_req), 1);

    wr(1'b1, 8'h4E);
    ticks(3);
    wr(1'b1, 8'h4E);
    ticks(3);
    chk("R4 clear key restarts counter", seen, 0);
    ticks(1);
    chk("R4 expiry counted from clear", int'(wdt_rst_req), 1);

    wr(1'b1, 8'h4E);
    ticks(3);
    wr(1'b1, 8'h55);
    wr(1'b1, 8'hB1);
    ticks(1);
    chk("R5 other keys do not restart", int'(wdt_rst_req), 1);

    wr(1'b1, 8'h4E);
    wr(1'b0, ctl(1'b0, 2'd3, 1'b1));
    wr(1'b1, 8'hB1);
    ticks(40);
    chk("R6 stopped watchdog silent", seen, 0);

    wr(1'b0, ctl(1'b1, 2'd3, 1'b1));
    ticks(3);
    chk("R8 restarted from zero", seen, 0);
    ticks(1);
    chk("R8 full timeout after restart", int'(wdt_rst_req), 1);

    wr(1'b1, 8'h4E);
    wr(1'b0, ctl(1'b1, 2'd3, 1'b1));
    wr(1'b0, ctl(1'b0, 2'd3, 1'b1));
    wr(1'b1, 8'hB1);
    ticks(4);
    chk("R7 unkeyed run=0 keeps running", int'(wdt_rst_req), 1);

    wr(1'b1, 8'h4E);
    wr(1'b0, ctl(1'b0, 2'd3, 1'b0));
    wr(1'b1, 8'h55);
    ticks(4);
    chk("R7 missing stop key keeps running", int'(wdt_nmi_req), 1);
    chk("R9 nmi mode keeps rst quiet", int'(wdt_rst_req), 0);

    finish_run();
  end
endmodule